// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Global Enable

This block decides which of twenty interrupt sources a processor core should service next. Each source has a pending request line and its own enable. A single global enable bit, held at bit 7 of an 8-bit status register, gates all of them. A source can win only when its own enable and the global enable are both set. Among the sources that can win, the lowest index always wins, and software cannot change that order.

When a source wins, the block raises a take strobe for one clock. In the same cycle it presents the source index and the vector address, and it pulses an acknowledge line to that source alone. The vector address is (index + 1) × 2, so slot 0 of the table stays free for reset. Acceptance clears the global enable, which masks every further request. A return-from-interrupt pulse sets the global enable again.

Software can write the whole status register at any time. Writing a one to bit 7 inside a handler therefore allows a nested interrupt. Nesting depth is not counted: every return simply sets the global enable. Stacking, saving the program counter and fetching instructions belong to the core.

Top module: `irqc_top`

## Requirements
- R1: After reset the status register reads 0x00 (global enable clear), the take strobe is low and every acknowledge line is low.
- R2: A pending source is taken only when its own enable bit and the global enable bit (status bit 7) are both 1. A pending source whose enable is 0 is ignored.
- R3: When several enabled sources are pending, the one with the lowest index is taken.
- R4: The take strobe is high for exactly one clock. In that clock exactly one acknowledge line is high, and it is the line of the reported index. At all other times no acknowledge line is high.
- R5: The reported vector address equals (index + 1) × 2. Address 0 is never produced for a source.
- R6: Acceptance clears the global enable. Status bit 7 reads 0 in the same cycle the take strobe is high, and the other status bits are unchanged.
- R7: A return pulse makes status bit 7 read 1 from the following cycle, unless an acceptance happens in that same cycle.
- R8: A software write loads all 8 status bits from the write data. Writing bit 7 as 1 while a handler runs lets an enabled pending source be taken again, including one of higher priority.
- R9: No source is taken in the cycle right after an acceptance. When an acceptance coincides with a return pulse or a software write, the acceptance wins and the global enable reads 0.
- R10: Each return pulse sets the global enable no matter how many returns came before it. No nesting depth is kept.
- R11: A request that arrives in a cycle where the global enable is 1 produces the take strobe one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 20 | Pending request per source |
| en_i | input | 20 | Enable per source |
| sr_wr_i | input | 1 | Software write strobe for the status register |
| sr_wdata_i | input | 8 | Status register write data; bit 7 is the global enable |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle strobe marking an accepted interrupt |
| vec_idx_o | output | 5 | Index of the accepted source |
| vec_addr_o | output | 8 | Vector address of the accepted source |
| ack_o | output | 20 | One-hot acknowledge to the accepted source |
| sr_o | output | 8 | Current status register |
| gie_o | output | 1 | Current global enable |

## Verification
Two things can land on the global enable bit in the same cycle. An acceptance clears it, while a return pulse or a software write tries to set it. The bench provokes this by leaving a source pending with the global enable already set, then raising a return pulse and a software write of 0x80 together in the cycle where acceptance is decided. The result is judged by the take strobe being high with status bit 7 reading 0. The strobe must then stay low for one cycle and come back only after a later return.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Decision for the global enable bit in the next cycle
   typedef enum logic [1:0] {
      GIE_HOLD = 2'd0,
      GIE_CLR  = 2'd1,
      GIE_SET  = 2'd2,
      GIE_SW   = 2'd3
   } gie_op_e;

   localparam int unsigned IRQC_SR_W_DEF = 8;
   localparam int unsigned IRQC_GIE_BIT_DEF = 7;
endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
   parameter  int unsigned N  = 20,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask_i,
   output logic          valid_o,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o
);
   // seen[k] is set when any source below k is live
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar gi = 0; gi < N; gi++) begin : g_chain
      assign grant_o[gi]  = mask_i[gi] & ~seen[gi];
      assign seen[gi + 1] = seen[gi] | mask_i[gi];
   end

   assign valid_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant_o[i]) idx_o = idx_o | IW'(i);
      end
   end
endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg
   import irqc_pkg::*;
#(
   parameter int unsigned SR_W    = IRQC_SR_W_DEF,
   parameter int unsigned GIE_BIT = IRQC_GIE_BIT_DEF
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            take_i,
   input  logic            reti_i,
   input  logic            wr_i,
   input  logic [SR_W-1:0] wdata_i,
   output logic [SR_W-1:0] sr_o,
   output logic            gie_o
);
   if (GIE_BIT >= SR_W) begin : g_bad_bit
      $fatal(1, "GIE_BIT must lie inside the status register");
   end

   logic [SR_W-1:0] sr_q, sr_d;
   gie_op_e         op;

   // acceptance beats return, return beats software write
   always_comb begin
      if (take_i)      op = GIE_CLR;
      else if (reti_i) op = GIE_SET;
      else if (wr_i)   op = GIE_SW;
      else             op = GIE_HOLD;
   end

   always_comb begin
      sr_d = wr_i ? wdata_i : sr_q;
      unique case (op)
         GIE_CLR:  sr_d[GIE_BIT] = 1'b0;
         GIE_SET:  sr_d[GIE_BIT] = 1'b1;
         GIE_SW:   sr_d[GIE_BIT] = wdata_i[GIE_BIT];
         default:  sr_d[GIE_BIT] = sr_q[GIE_BIT];
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= sr_d;
   end

   assign sr_o  = sr_q;
   assign gie_o = sr_q[GIE_BIT];

   // R6
   take_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> !gie_o);
   // R7
   reti_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i && !take_i) |=> gie_o);
endmodule

// File: rtl/irqc_vec_gen.sv
module irqc_vec_gen #(
   parameter int unsigned IW          = 5,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned STRIDE      = 2,
   parameter int unsigned RESET_SLOTS = 1
) (
   input  logic [IW-1:0]     idx_i,
   output logic [ADDR_W-1:0] addr_o
);
   if (STRIDE == 0) begin : g_bad_stride
      $fatal(1, "STRIDE must be nonzero");
   end

   if ((STRIDE & (STRIDE - 1)) == 0) begin : g_shift
      localparam int unsigned SH = $clog2(STRIDE);
      assign addr_o = ADDR_W'((32'(idx_i) + RESET_SLOTS) << SH);
   end else begin : g_mult
      assign addr_o = ADDR_W'((32'(idx_i) + RESET_SLOTS) * STRIDE);
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter  int unsigned NUM_SRC     = 20,
   parameter  int unsigned SR_W        = IRQC_SR_W_DEF,
   parameter  int unsigned GIE_BIT     = IRQC_GIE_BIT_DEF,
   parameter  int unsigned ADDR_W      = 8,
   parameter  int unsigned STRIDE      = 2,
   parameter  int unsigned RESET_SLOTS = 1,
   localparam int unsigned IW          = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic               sr_wr_i,
   input  logic [SR_W-1:0]    sr_wdata_i,
   input  logic               reti_i,
   output logic               take_o,
   output logic [IW-1:0]      vec_idx_o,
   output logic [ADDR_W-1:0]  vec_addr_o,
   output logic [NUM_SRC-1:0] ack_o,
   output logic [SR_W-1:0]    sr_o,
   output logic               gie_o
);
   localparam int unsigned TOP_ADDR = (NUM_SRC + RESET_SLOTS) * STRIDE;

   if (NUM_SRC < 1) begin : g_bad_n
      $fatal(1, "NUM_SRC must be at least 1");
   end
   if (TOP_ADDR > (1 << ADDR_W)) begin : g_bad_aw
      $fatal(1, "ADDR_W too narrow for the vector table");
   end
   if (RESET_SLOTS < 1) begin : g_bad_rs
      $fatal(1, "at least one slot must stay reserved for reset");
   end

   logic [NUM_SRC-1:0] live_w, grant_w;
   logic [IW-1:0]      idx_w;
   logic [ADDR_W-1:0]  addr_w;
   logic               any_w, accept_w;

   logic               take_q;
   logic [IW-1:0]      idx_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [NUM_SRC-1:0] ack_q;

   assign live_w = req_i & en_i;

   irqc_prio_pick #(.N(NUM_SRC)) pick_i (
      .mask_i  (live_w),
      .valid_o (any_w),
      .grant_o (grant_w),
      .idx_o   (idx_w)
   );

   irqc_vec_gen #(
      .IW          (IW),
      .ADDR_W      (ADDR_W),
      .STRIDE      (STRIDE),
      .RESET_SLOTS (RESET_SLOTS)
   ) vgen_i (
      .idx_i  (idx_w),
      .addr_o (addr_w)
   );

   // no acceptance in the cycle that follows one
   assign accept_w = gie_o & ~take_q & any_w;

   irqc_status_reg #(.SR_W(SR_W), .GIE_BIT(GIE_BIT)) sreg_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (accept_w),
      .reti_i  (reti_i),
      .wr_i    (sr_wr_i),
      .wdata_i (sr_wdata_i),
      .sr_o    (sr_o),
      .gie_o   (gie_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         take_q <= 1'b0;
         idx_q  <= '0;
         addr_q <= '0;
         ack_q  <= '0;
      end else begin
         take_q <= accept_w;
         ack_q  <= accept_w ? grant_w : '0;
         if (accept_w) begin
            idx_q  <= idx_w;
            addr_q <= addr_w;
         end
      end
   end

   assign take_o     = take_q;
   assign vec_idx_o  = idx_q;
   assign vec_addr_o = addr_q;
   assign ack_o      = ack_q;

   // R4
   ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ($countones(ack_o) == 1));
   // R4
   ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_o |-> (ack_o == '0));
   // R4
   ack_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ack_o[vec_idx_o]);
   // R9
   take_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> !take_o);
   // R6
   gie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> !gie_o);
   // R2
   grant_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> ($past(gie_o) && ((($past(live_w) >> vec_idx_o) & NUM_SRC'(1)) != '0)));
   // R3
   lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (($past(live_w) & ((NUM_SRC'(1) << vec_idx_o) - NUM_SRC'(1))) == '0));
   // R5
   addr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (vec_addr_o != '0));
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
   localparam int N = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  en = '0;
   logic          sr_wr = 1'b0;
   logic [7:0]    sr_wdata = '0;
   logic          reti = 1'b0;
   logic          take;
   logic [4:0]    vidx;
   logic [7:0]    vaddr;
   logic [N-1:0]  ack;
   logic [7:0]    sr;
   logic          gie;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irqc_top dut_i (
      .clk_i (clk), .rst_ni (rst_n), .req_i (req), .en_i (en),
      .sr_wr_i (sr_wr), .sr_wdata_i (sr_wdata), .reti_i (reti),
      .take_o (take), .vec_idx_o (vidx), .vec_addr_o (vaddr),
      .ack_o (ack), .sr_o (sr), .gie_o (gie)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic sw_write(input logic [7:0] v);
      sr_wr = 1'b1; sr_wdata = v;
      step();
      sr_wr = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      step();
      reti = 1'b0;
   endtask

   task automatic expect_take(input string rq, input int idx);
      chk(rq, "take", 32'(take), 32'd1);
      chk(rq, "index", 32'(vidx), 32'(idx));
      chk(rq, "addr", 32'(vaddr), 32'((idx + 1) * 2));
      chk(rq, "ack", 32'(ack), 32'(N'(1) << idx));
      chk(rq, "gie", 32'(gie), 32'd0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1", "sr", 32'(sr), 32'h0);
      chk("R1", "take", 32'(take), 32'd0);
      chk("R1", "ack", 32'(ack), 32'd0);

      // R2: enabled pending source, global enable off -> nothing
      req = '1; en = '1;
      step(); step();
      chk("R2", "take with gie=0", 32'(take), 32'd0);
      // R2: global enable on, all source enables off -> nothing
      en = '0;
      sw_write(8'h80);
      step(); step();
      chk("R2", "take with en=0", 32'(take), 32'd0);
      chk("R2", "gie kept", 32'(gie), 32'd1);
      sw_write(8'h00);

      // R2 R5 R11: each source alone by its enable, all requests high
      for (int i = 0; i < N; i++) begin
         en = N'(1) << i;
         sw_write(8'h80);
         step();
         expect_take("R5", i);
         step();
         chk("R4", "strobe one cycle", 32'(take), 32'd0);
         chk("R4", "ack idle", 32'(ack), 32'd0);
      end

      // R3: every pair of sources
      en = '1;
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            req = (N'(1) << i) | (N'(1) << j);
            sw_write(8'h80);
            step();
            expect_take("R3", i);
            req = '0;
            step();
         end
      end

      // R6 R8: other status bits survive acceptance
      req = '0;
      sw_write(8'h5A);
      chk("R8", "sr write", 32'(sr), 32'h5A);
      chk("R8", "gie from write", 32'(gie), 32'd0);
      req = N'(1) << 9;
      sw_write(8'h85);
      step();
      expect_take("R6", 9);
      chk("R6", "low bits kept", 32'(sr), 32'h05);

      // R8 nesting: handler for 9 re-enables, higher-priority 2 arrives
      req = (N'(1) << 9) | (N'(1) << 2);
      step();
      sw_write(8'h80);
      step();
      expect_take("R8", 2);
      req = '0;
      step();

      // R7 R10: two returns, each sets gie
      do_reti();
      chk("R7", "gie after reti", 32'(gie), 32'd1);
      sw_write(8'h00);
      do_reti();
      chk("R10", "gie after 2nd reti", 32'(gie), 32'd1);
      do_reti();
      chk("R10", "gie after 3rd reti", 32'(gie), 32'd1);
      chk("R10", "no take", 32'(take), 32'd0);
      sw_write(8'h00);

      // R9: acceptance collides with return and software write
      sw_write(8'h80);              // gie=1, nothing pending
      req = N'(1) << 7;
      reti = 1'b1; sr_wr = 1'b1; sr_wdata = 8'h80;
      step();
      reti = 1'b0; sr_wr = 1'b0;
      expect_take("R9", 7);
      // return during the strobe cycle: no back-to-back take
      reti = 1'b1;
      step();
      reti = 1'b0;
      chk("R9", "no take after take", 32'(take), 32'd0);
      chk("R9", "gie set by reti", 32'(gie), 32'd1);
      step();
      expect_take("R11", 7);
      req = '0;
      step();
      chk("R9", "idle", 32'(take), 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule